// File: doc/BRIEF.md
# Motor drive output formatter

This block sits between a servo filter and the motor power stage. Once per sample period the filter hands it a signed drive value with a one-cycle `sample_vld` pulse. The block limits that value and presents it in three forms. The first is an offset-binary code for an external DAC, as one steady 8-bit byte or as a 12-bit word sent in two 6-bit halves. The second is a direction bit. The third is a pulse-width modulated magnitude for a switch-mode amplifier, which runs alongside the DAC output.

In offset binary the middle code means zero torque. Codes below it command negative torque and codes above it command positive torque. In the 12-bit format the block also drives two strobes. An external 6-bit latch uses them to capture the upper half and to know when the full word is present on the bus. A static mode input chooses between the 8-bit and 12-bit DAC formats. The PWM output does not depend on that choice.

Top module: `motor_drive_fmt`

## Requirements
- R1: With `wide_mode` = 0, the cycle after a `sample_vld` edge `dac_bus` shows the drive value clamped to -128..127 and then offset by 128, so zero gives 0x80, -128 or less gives 0x00, and 127 or more gives 0xFF.
- R2: With `wide_mode` = 0, `dac_bus` holds its last code between samples, and changes on `drive_val` without `sample_vld` have no effect on it.
- R3: With `wide_mode` = 1, the 12-bit code is the drive value clamped to -2048..2047 and then offset by 2048, so zero gives 0x800.
- R4: With `wide_mode` = 1, the cycle after a sample `dac_bus[5:0]` shows code bits 11..6 with `hi_stb` = 1. The next cycle it shows code bits 5..0 with `word_stb` = 1 and `hi_stb` = 0. After that `word_stb` is 0 and the low half stays on the bus. Bits 7..6 of `dac_bus` are 0 in this mode, and the two strobes are never high together.
- R5: With `wide_mode` = 0, `hi_stb` and `word_stb` stay at 0.
- R6: The cycle after a sample, `pwm_sign` is 1 exactly when the sampled drive value is negative.
- R7: The PWM magnitude is min(|drive|, 255). Over any 256 consecutive cycles `pwm_out` is high for exactly that many cycles. A magnitude of 0 gives a constant-low `pwm_out`.
- R8: While reset is asserted, and after it is released until the first sample, the outputs show zero torque: `dac_bus` = 0x80 in 8-bit mode, `dac_bus` = 0x00 (the low half of 0x800) in 12-bit mode, both strobes at 0, `pwm_sign` = 0 and `pwm_out` constantly low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample_vld | input | 1 | One-cycle pulse that captures `drive_val` |
| wide_mode | input | 1 | 0 = 8-bit DAC byte, 1 = 12-bit value in two 6-bit halves |
| drive_val | input | 16 | Signed two's-complement motor drive command |
| dac_bus | output | 8 | DAC code (8-bit mode) or current 6-bit half in bits 5..0 (12-bit mode) |
| hi_stb | output | 1 | High for the cycle the upper half is on the bus |
| word_stb | output | 1 | High for the cycle the lower half completes the 12-bit word |
| pwm_out | output | 1 | PWM magnitude waveform, 256-cycle period |
| pwm_sign | output | 1 | Direction: 1 for negative drive |

## Verification
The properties assume that `wide_mode` changes only while no transfer is in progress. They also assume that in 12-bit mode two `sample_vld` pulses are at least two cycles apart, so the low half always gets its strobe cycle. The input-spacing property states the second assumption as a check on the inputs. The stimulus sets the mode only before it raises `sample_vld`, and it spaces 12-bit samples by a full PWM period. Back-to-back pulses are used only in 8-bit mode, where nothing is multiplexed.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  typedef enum logic {
    FMT_NARROW = 1'b0,
    FMT_WIDE   = 1'b1
  } dac_fmt_e;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } half_ph_e;

endpackage

// File: rtl/mdf_rst_sync.sv
module mdf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mdf_offset_enc.sv
module mdf_offset_enc #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0] drive,
  output logic        [OUT_W-1:0] code
);

  localparam int EXT_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] POS_LIM = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] NEG_LIM = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] clamped;

  always_comb begin
    if (drive > POS_LIM) begin
      clamped = POS_LIM;
    end else if (drive < NEG_LIM) begin
      clamped = NEG_LIM;
    end else begin
      clamped = drive;
    end
  end

  // Adding the half-scale offset to a two's-complement value is an MSB flip.
  assign code = {~clamped[OUT_W-1], clamped[OUT_W-2:0]};

endmodule

// File: rtl/mdf_dac_port.sv
module mdf_dac_port
  import mdf_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_vld,
  input  logic                wide_mode,
  input  logic [NARROW_W-1:0] code_n,
  input  logic [WIDE_W-1:0]   code_w,
  output logic [NARROW_W-1:0] dac_bus,
  output logic                hi_stb,
  output logic                word_stb
);

  localparam int HALF_W = WIDE_W / 2;
  localparam int PAD_W  = NARROW_W - HALF_W;
  localparam logic [NARROW_W-1:0] ZERO_N  = {1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [HALF_W-1:0]   ZERO_HI = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [HALF_W-1:0]   ZERO_LO = '0;

  dac_fmt_e fmt;
  assign fmt = dac_fmt_e'(wide_mode);

  logic [NARROW_W-1:0] byte_q, byte_d;
  logic [HALF_W-1:0]   hi_q, hi_d;
  logic [HALF_W-1:0]   lo_q, lo_d;
  half_ph_e            ph_q, ph_d;
  logic                hs_q, hs_d;
  logic                ws_q, ws_d;
  logic                code_en;
  logic                ph_en;

  // Next-state logic
  always_comb begin
    byte_d  = byte_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    ph_d    = ph_q;
    hs_d    = 1'b0;
    ws_d    = 1'b0;
    code_en = sample_vld;
    ph_en   = 1'b0;
    if (sample_vld) begin
      byte_d = code_n;
      hi_d   = code_w[WIDE_W-1:HALF_W];
      lo_d   = code_w[HALF_W-1:0];
      if (fmt == FMT_WIDE) begin
        ph_d  = PH_HIGH;
        ph_en = 1'b1;
        hs_d  = 1'b1;
      end
    end else if (hs_q) begin
      ph_d  = PH_LOW;
      ph_en = 1'b1;
      ws_d  = 1'b1;
    end
  end

  // Code registers, loaded once per sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= ZERO_N;
      hi_q   <= ZERO_HI;
      lo_q   <= ZERO_LO;
    end else if (code_en) begin
      byte_q <= byte_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  // Half-select phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_LOW;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  // Strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ws_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ws_q <= ws_d;
    end
  end

  logic [HALF_W-1:0] half_sel;
  assign half_sel = (ph_q == PH_LOW) ? lo_q : hi_q;

  logic [NARROW_W-1:0] wide_bus;
  generate
    if (PAD_W > 0) begin : g_pad
      assign wide_bus = {{PAD_W{1'b0}}, half_sel};
    end else begin : g_nopad
      assign wide_bus = half_sel;
    end
  endgenerate

  assign dac_bus  = (fmt == FMT_WIDE) ? wide_bus : byte_q;
  assign hi_stb   = hs_q;
  assign word_stb = ws_q;

endmodule

// File: rtl/mdf_pwm_gen.sv
module mdf_pwm_gen #(
  parameter int IN_W  = 16,
  parameter int PWM_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_vld,
  input  logic signed [IN_W-1:0] drive,
  output logic                   pwm_out,
  output logic                   pwm_sign
);

  localparam logic signed [IN_W-1:0] MAG_LIM =
    {{(IN_W-PWM_W){1'b0}}, {PWM_W{1'b1}}};
  localparam logic signed [IN_W-1:0] NEG_MAG_LIM = -MAG_LIM;

  logic signed [IN_W-1:0] neg_drive;
  logic [PWM_W-1:0]       mag_d, mag_q;
  logic                   sign_d, sign_q;
  logic [PWM_W-1:0]       cnt_d, cnt_q;

  assign neg_drive = -drive;

  // Magnitude and sign of the new sample
  always_comb begin
    sign_d = drive[IN_W-1];
    if (drive > MAG_LIM || drive < NEG_MAG_LIM) begin
      mag_d = {PWM_W{1'b1}};
    end else if (drive[IN_W-1]) begin
      mag_d = neg_drive[PWM_W-1:0];
    end else begin
      mag_d = drive[PWM_W-1:0];
    end
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      sign_q <= 1'b0;
    end else if (sample_vld) begin
      mag_q  <= mag_d;
      sign_q <= sign_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign pwm_out  = (cnt_q < mag_q);
  assign pwm_sign = sign_q;

endmodule

// File: rtl/motor_drive_fmt.sv
module motor_drive_fmt #(
  parameter int DRIVE_W  = 16,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 12,
  parameter int PWM_W    = 8,
  parameter int SYNC_STG = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_vld,
  input  logic                       wide_mode,
  input  logic signed [DRIVE_W-1:0]  drive_val,
  output logic [NARROW_W-1:0]        dac_bus,
  output logic                       hi_stb,
  output logic                       word_stb,
  output logic                       pwm_out,
  output logic                       pwm_sign
);

  logic                rst_sync_n;
  logic [NARROW_W-1:0] code_n;
  logic [WIDE_W-1:0]   code_w;

  mdf_rst_sync #(
    .STAGES(SYNC_STG)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdf_offset_enc #(
    .IN_W  (DRIVE_W),
    .OUT_W (NARROW_W)
  ) u_enc_n (
    .drive (drive_val),
    .code  (code_n)
  );

  mdf_offset_enc #(
    .IN_W  (DRIVE_W),
    .OUT_W (WIDE_W)
  ) u_enc_w (
    .drive (drive_val),
    .code  (code_w)
  );

  mdf_dac_port #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) u_dac (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sample_vld (sample_vld),
    .wide_mode  (wide_mode),
    .code_n     (code_n),
    .code_w     (code_w),
    .dac_bus    (dac_bus),
    .hi_stb     (hi_stb),
    .word_stb   (word_stb)
  );

  mdf_pwm_gen #(
    .IN_W  (DRIVE_W),
    .PWM_W (PWM_W)
  ) u_pwm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sample_vld (sample_vld),
    .drive      (drive_val),
    .pwm_out    (pwm_out),
    .pwm_sign   (pwm_sign)
  );

endmodule

// File: rtl/mdf_chk.sv
module mdf_chk #(
  parameter int DRIVE_W  = 16,
  parameter int NARROW_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_vld,
  input  logic                      wide_mode,
  input  logic signed [DRIVE_W-1:0] drive_val,
  input  logic [NARROW_W-1:0]       dac_bus,
  input  logic                      hi_stb,
  input  logic                      word_stb,
  input  logic                      pwm_out,
  input  logic                      pwm_sign
);

  // R1
  narrow_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !wide_mode) |=>
      (wide_mode || (dac_bus[NARROW_W-1] != $past(drive_val[DRIVE_W-1]))));

  // R2
  narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && !wide_mode) |=> (wide_mode || $stable(dac_bus)));

  // R4
  hi_then_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb |=> (word_stb && !hi_stb));

  // R4
  word_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_stb, word_stb}));

  // R5
  narrow_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !wide_mode) |=> !hi_stb);

  // R6
  sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> (pwm_sign == $past(drive_val[DRIVE_W-1])));

  // R7
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && drive_val == '0) |=> !pwm_out);

  // R4 input spacing in 12-bit mode
  wide_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && wide_mode) |=> !sample_vld);

endmodule

bind motor_drive_fmt mdf_chk #(
  .DRIVE_W  (DRIVE_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sample_vld (sample_vld),
  .wide_mode  (wide_mode),
  .drive_val  (drive_val),
  .dac_bus    (dac_bus),
  .hi_stb     (hi_stb),
  .word_stb   (word_stb),
  .pwm_out    (pwm_out),
  .pwm_sign   (pwm_sign)
);

// File: tb/sim_motor_drive_fmt.sv
`timescale 1ns/1ps
module sim_motor_drive_fmt;

  logic              clk;
  logic              rst_n;
  logic              sample_vld;
  logic              wide_mode;
  logic signed [15:0] drive_val;
  logic [7:0]        dac_bus;
  logic              hi_stb;
  logic              word_stb;
  logic              pwm_out;
  logic              pwm_sign;

  int nchk;
  int nfail;
  bit done;

  motor_drive_fmt u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .wide_mode  (wide_mode),
    .drive_val  (drive_val),
    .dac_bus    (dac_bus),
    .hi_stb     (hi_stb),
    .word_stb   (word_stb),
    .pwm_out    (pwm_out),
    .pwm_sign   (pwm_sign)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {mode, drive, code or high half, low half, magnitude, sign}
  localparam int NV = 16;
  localparam logic [41:0] VECS [NV] = '{
    {1'b0, 16'h0000, 8'h80, 8'h00, 8'd0,   1'b0},
    {1'b0, 16'h0005, 8'h85, 8'h00, 8'd5,   1'b0},
    {1'b0, 16'hFFFF, 8'h7F, 8'h00, 8'd1,   1'b1},
    {1'b0, 16'h007F, 8'hFF, 8'h00, 8'd127, 1'b0},
    {1'b0, 16'h0080, 8'hFF, 8'h00, 8'd128, 1'b0},
    {1'b0, 16'hFF80, 8'h00, 8'h00, 8'd128, 1'b1},
    {1'b0, 16'hFED4, 8'h00, 8'h00, 8'd255, 1'b1},
    {1'b0, 16'h03E8, 8'hFF, 8'h00, 8'd255, 1'b0},
    {1'b1, 16'h0000, 8'h20, 8'h00, 8'd0,   1'b0},
    {1'b1, 16'h0123, 8'h24, 8'h23, 8'd255, 1'b0},
    {1'b1, 16'hFFFF, 8'h1F, 8'h3F, 8'd1,   1'b1},
    {1'b1, 16'h07FF, 8'h3F, 8'h3F, 8'd255, 1'b0},
    {1'b1, 16'h1388, 8'h3F, 8'h3F, 8'd255, 1'b0},
    {1'b1, 16'hF800, 8'h00, 8'h00, 8'd255, 1'b1},
    {1'b1, 16'h8000, 8'h00, 8'h00, 8'd255, 1'b1},
    {1'b1, 16'hFF9C, 8'h1E, 8'h1C, 8'd100, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic count_high(output int hc);
    hc = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) hc++;
    end
  endtask

  task automatic apply(input logic mode, input logic [15:0] d);
    @(negedge clk);
    wide_mode  = mode;
    drive_val  = d;
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic run_vec(input logic [41:0] v);
    int hc;
    apply(v[41], v[40:25]);
    if (v[41]) begin
      chk("R3 high half", {24'd0, dac_bus}, {24'd0, v[24:17]});
      chk("R4 hi_stb first", {31'd0, hi_stb}, 32'd1);
      chk("R4 word_stb idle", {31'd0, word_stb}, 32'd0);
      @(negedge clk);
      chk("R3 low half", {24'd0, dac_bus}, {24'd0, v[16:9]});
      chk("R4 word_stb second", {31'd0, word_stb}, 32'd1);
      chk("R4 hi_stb cleared", {31'd0, hi_stb}, 32'd0);
      @(negedge clk);
      chk("R4 word_stb ends", {31'd0, word_stb}, 32'd0);
      chk("R4 low half held", {24'd0, dac_bus}, {24'd0, v[16:9]});
    end else begin
      chk("R1 byte code", {24'd0, dac_bus}, {24'd0, v[24:17]});
      chk("R5 no hi_stb", {31'd0, hi_stb}, 32'd0);
      drive_val = ~v[40:25];
      @(negedge clk);
      chk("R2 byte held", {24'd0, dac_bus}, {24'd0, v[24:17]});
      chk("R5 no word_stb", {31'd0, word_stb}, 32'd0);
      @(negedge clk);
      chk("R2 byte still held", {24'd0, dac_bus}, {24'd0, v[24:17]});
    end
    chk("R6 sign", {31'd0, pwm_sign}, {31'd0, v[0]});
    count_high(hc);
    chk("R7 duty", hc, {24'd0, v[8:1]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int hc;
    nchk = 0;
    nfail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    sample_vld = 1'b0;
    wide_mode = 1'b0;
    drive_val = 16'sd0;

    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 narrow zero code", {24'd0, dac_bus}, 32'h80);
    chk("R8 strobes low", {30'd0, hi_stb, word_stb}, 32'd0);
    chk("R8 pwm low", {30'd0, pwm_out, pwm_sign}, 32'd0);
    wide_mode = 1'b1;
    @(negedge clk);
    chk("R8 wide zero low half", {24'd0, dac_bus}, 32'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 wide after release", {24'd0, dac_bus}, 32'h00);
    count_high(hc);
    chk("R8 R7 zero duty after reset", hc, 32'd0);
    wide_mode = 1'b0;
    @(negedge clk);
    chk("R8 narrow after release", {24'd0, dac_bus}, 32'h80);

    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k]);
    end

    // R1 back-to-back samples in 8-bit mode
    @(negedge clk);
    wide_mode = 1'b0;
    drive_val = 16'sd10;
    sample_vld = 1'b1;
    @(negedge clk);
    chk("R1 first of pair", {24'd0, dac_bus}, 32'h8A);
    drive_val = 16'sd20;
    @(negedge clk);
    sample_vld = 1'b0;
    chk("R1 second of pair", {24'd0, dac_bus}, 32'h94);
    chk("R5 pair no strobe", {30'd0, hi_stb, word_stb}, 32'd0);

    // R8 reset in the middle of operation
    apply(1'b0, 16'hFED4);
    chk("R6 negative before reset", {31'd0, pwm_sign}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R8 mid-run code", {24'd0, dac_bus}, 32'h80);
    chk("R8 mid-run pwm", {30'd0, pwm_out, pwm_sign}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    count_high(hc);
    chk("R8 mid-run duty", hc, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule